// File: doc/BRIEF.md
# Aliased Interrupt Pending Register Bank

This block holds one pending flag per voltage domain for threshold-crossing interrupts and exposes that single set of flags at two register addresses. The first address, the raw view, returns every pending flag unmasked, and writing ones there forces flags high so that software can inject an interrupt on purpose. The second address, the status view, returns the flags ANDed with an enable mask, and writing ones there acknowledges (clears) flags. Because both addresses act on the same storage, a write through either view is seen at once by reads of both.

A separate enable mask has one address for write-one-to-set and one for write-one-to-clear, and both addresses read back the current mask. Hardware event pulses set pending flags directly. A single interrupt line, taken from a flop, reports whether any enabled flag is pending.

Top module: `irq_alias_regbank`

## Requirements
- R1: After a synchronous active-low reset (rst_n low at a clock edge), all pending flags, all mask bits and irq_out are 0.
- R2: A write to offset 0x0 sets each pending flag whose wdata bit (bit i for domain i, bits 7:0) is 1. Flags whose wdata bit is 0 keep their value.
- R3: A read of offset 0x0 returns all pending flags in bits 7:0, whatever the mask holds.
- R4: A read of offset 0x4 returns the pending flags ANDed bitwise with the enable mask in bits 7:0.
- R5: A write to offset 0x4 clears each pending flag whose wdata bit is 1. Flags whose wdata bit is 0 keep their value. The change is visible through both offsets 0x0 and 0x4.
- R6: A high hw_evt[i] at a clock edge sets pending flag i at that edge. If a clear of the same flag arrives through offset 0x4 at the same edge, the flag ends up set.
- R7: A write to offset 0x8 sets mask bits where wdata is 1, and a write to offset 0xC clears mask bits where wdata is 1. Reads of either offset return the mask in bits 7:0.
- R8: irq_out is registered and equals the OR of (pending AND mask) as held in the previous cycle. It changes one clock after the flags or mask change.
- R9: Read bits 31:8 are always 0, and wdata bits 31:8 have no effect on any state.
- R10: Reads of any address other than 0x0, 0x4, 0x8 and 0xC return 0. Writes to such addresses change neither the flags nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| hw_evt | input | 8 | Per-domain event pulses that set pending flags |
| irq_out | output | 1 | Registered OR of the enabled pending flags |

## Verification
The bench sweeps all 256 pending patterns against a mask derived from each pattern. This catches a design that swaps the masked and unmasked views, that applies the mask to storage instead of only to the read path, or that does not share one store between the two aliases. It sends a hardware event and a software clear to the same flag at the same edge, so a design that lets the clear win loses the flag. It checks irq_out one cycle at a time after a flag is set and after the mask is dropped, which exposes an output that is combinational or two cycles late. It also writes upper data bits and unmapped offsets, which catches loose address decoding and reserved bits that are stored.

// File: rtl/irq_alias_pkg.sv
package irq_alias_pkg;

    localparam int DOM_N  = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_RAW  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ENS  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_ENC  = 8'h0C;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RAW  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_MASK = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic raw_set;
        logic stat_clr;
        logic en_set;
        logic en_clr;
    } wr_strb_t;

    function automatic rd_sel_e addr_to_sel(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_RAW:          return SEL_RAW;
            OFS_STAT:         return SEL_STAT;
            OFS_ENS, OFS_ENC: return SEL_MASK;
            default:          return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_alias_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output wr_strb_t          strb,
    output rd_sel_e           sel
);

    always_comb begin
        strb          = '0;
        strb.raw_set  = wr_en && (addr == OFS_RAW);
        strb.stat_clr = wr_en && (addr == OFS_STAT);
        strb.en_set   = wr_en && (addr == OFS_ENS);
        strb.en_clr   = wr_en && (addr == OFS_ENC);
        sel           = addr_to_sel(addr);
    end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] sw_set,
    input  logic [NB-1:0] sw_clr,
    input  logic [NB-1:0] hw_set,
    output logic [NB-1:0] pend
);

    for (genvar i = 0; i < NB; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else if (hw_set[i] || sw_set[i]) begin
                pend[i] <= 1'b1;
            end else if (sw_clr[i]) begin
                pend[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_bits,
    input  logic [NB-1:0] clr_bits,
    output logic [NB-1:0] mask
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else begin
            mask <= (mask | set_bits) & ~clr_bits;
        end
    end

endmodule

// File: rtl/irq_alias_regbank.sv
module irq_alias_regbank
    import irq_alias_pkg::*;
#(
    parameter int NDOM  = DOM_N,
    parameter int DWID  = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DWID-1:0]   wdata,
    output logic [DWID-1:0]   rdata,
    input  logic [NDOM-1:0]   hw_evt,
    output logic              irq_out
);

    wr_strb_t        strb;
    rd_sel_e         sel;
    logic [NDOM-1:0] wlo;
    logic [NDOM-1:0] pend_q;
    logic [NDOM-1:0] mask_q;
    logic [NDOM-1:0] rd_lo;
    logic            irq_q;
    logic            unused_rsvd;

    assign wlo         = wdata[NDOM-1:0];
    assign unused_rsvd = ^wdata[DWID-1:NDOM];

    irq_addr_decode u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .strb  (strb),
        .sel   (sel)
    );

    irq_pend_bank #(.NB(NDOM)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (strb.raw_set  ? wlo : '0),
        .sw_clr (strb.stat_clr ? wlo : '0),
        .hw_set (hw_evt),
        .pend   (pend_q)
    );

    irq_mask_reg #(.NB(NDOM)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (strb.en_set ? wlo : '0),
        .clr_bits (strb.en_clr ? wlo : '0),
        .mask     (mask_q)
    );

    always_comb begin
        case (sel)
            SEL_RAW:  rd_lo = pend_q;
            SEL_STAT: rd_lo = pend_q & mask_q;
            SEL_MASK: rd_lo = mask_q;
            default:  rd_lo = '0;
        endcase
        rdata             = '0;
        rdata[NDOM-1:0]   = rd_lo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(pend_q & mask_q);
        end
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/irq_alias_chk.sv
module irq_alias_chk
    import irq_alias_pkg::*;
#(
    parameter int NDOM = DOM_N,
    parameter int DWID = DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DWID-1:0]   wdata,
    input logic [DWID-1:0]   rdata,
    input logic [NDOM-1:0]   hw_evt,
    input logic              irq_out,
    input logic [NDOM-1:0]   pend,
    input logic [NDOM-1:0]   mask
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && mask == '0 && !irq_out));

    // R2
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_RAW) |=>
            ((pend & $past(wdata[NDOM-1:0])) == $past(wdata[NDOM-1:0])));

    // R5
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_STAT) |=>
            ((pend & $past(wdata[NDOM-1:0] & ~hw_evt)) == '0));

    // R6
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt != '0) |=> ((pend & $past(hw_evt)) == $past(hw_evt)));

    // R7
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_ENC) |=>
            ((mask & $past(wdata[NDOM-1:0])) == '0));

    // R8
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_out == $past(|(pend & mask))));

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DWID-1:NDOM] == '0);

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != OFS_RAW && addr != OFS_STAT && addr != OFS_ENS && addr != OFS_ENC)
            |-> (rdata == '0));

    // R10
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != OFS_RAW && addr != OFS_STAT && addr != OFS_ENS && addr != OFS_ENC
         && hw_evt == '0) |=> ($stable(pend) && $stable(mask)));

endmodule

bind irq_alias_regbank irq_alias_chk #(.NDOM(NDOM), .DWID(DWID)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .hw_evt  (hw_evt),
    .irq_out (irq_out),
    .pend    (pend_q),
    .mask    (mask_q)
);

// File: tb/irq_alias_regbank_bench.sv
`timescale 1ns/1ps
module irq_alias_regbank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  hw_evt = '0;
    logic        irq_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_alias_regbank u_irq_alias_regbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .hw_evt  (hw_evt),
        .irq_out (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    initial begin
        logic [7:0] m;
        logic [7:0] c;
        logic [7:0] keep;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_check("R1 raw", 8'h00, 32'h0);
        rd_check("R1 mask", 8'h08, 32'h0);
        check("R1 irq", {31'b0, irq_out}, 32'h0);

        // Sweep all pending patterns
        for (int v = 0; v < 256; v++) begin
            m = 8'((v * 37 + 11) & 8'hFF);
            c = 8'(v) ^ 8'h5A;
            wr(8'h04, 32'hFF);
            wr(8'h0C, 32'hFF);
            wr(8'h08, {24'b0, m});
            wr(8'h00, {24'b0, 8'(v)});
            rd_check("R2 raw set", 8'h00, {24'b0, 8'(v)});
            rd_check("R3 raw unmasked", 8'h00, {24'b0, 8'(v)});
            rd_check("R4 masked view", 8'h04, {24'b0, 8'(v) & m});
            rd_check("R7 mask at set ofs", 8'h08, {24'b0, m});
            wr(8'h00, 32'h0);
            rd_check("R2 zero write keeps", 8'h00, {24'b0, 8'(v)});
            wr(8'h04, {24'b0, c});
            rd_check("R5 clear raw", 8'h00, {24'b0, 8'(v) & ~c});
            rd_check("R5 clear status", 8'h04, {24'b0, 8'(v) & ~c & m});
        end

        // R7 mask clear and readback at clear offset
        wr(8'h0C, 32'hFF);
        wr(8'h08, 32'hC3);
        wr(8'h0C, 32'h41);
        rd_check("R7 mask clear ofs", 8'h0C, 32'h82);
        rd_check("R7 mask set ofs", 8'h08, 32'h82);

        // R9 reserved bits
        wr(8'h04, 32'hFF);
        wr(8'h00, 32'hFFFFFF00);
        rd_check("R9 upper write ignored", 8'h00, 32'h0);
        wr(8'h00, 32'hFFFFFFFF);
        rd_check("R9 upper read zero", 8'h00, 32'h000000FF);

        // R10 unmapped addresses
        keep = 8'hFF;
        for (int a = 0; a < 64; a++) begin
            if ((a & 3) != 0 || a > 12) begin
                wr(8'(a), 32'h0);
                rd_check("R10 unmapped read", 8'(a), 32'h0);
            end
        end
        wr(8'h10, 32'hFF);
        wr(8'h05, 32'hFF);
        wr(8'h0D, 32'hFF);
        rd_check("R10 no pend change", 8'h00, {24'b0, keep});
        rd_check("R10 no mask change", 8'h08, 32'h82);

        // R6 hardware events
        wr(8'h04, 32'hFF);
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            hw_evt = 8'(1 << b);
            @(negedge clk);
            hw_evt = '0;
            rd_check("R6 hw set", 8'h00, {24'b0, 8'((2 << b) - 1)});
        end
        @(negedge clk);
        hw_evt = 8'h24; wr_en = 1'b1; addr = 8'h04; wdata = 32'hFF;
        @(negedge clk);
        hw_evt = '0; wr_en = 1'b0; wdata = '0;
        rd_check("R6 set beats clear", 8'h00, 32'h24);

        // R8 irq timing
        wr(8'h04, 32'hFF);
        wr(8'h0C, 32'hFF);
        wr(8'h08, 32'h01);
        @(negedge clk);
        check("R8 idle low", {31'b0, irq_out}, 32'h0);
        wr(8'h00, 32'h01);
        check("R8 not same cycle", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R8 high next cycle", {31'b0, irq_out}, 32'h1);
        wr(8'h0C, 32'h01);
        check("R8 holds one cycle", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R8 low after mask drop", {31'b0, irq_out}, 32'h0);
        wr(8'h00, 32'h80);
        @(negedge clk);
        check("R8 masked flag no irq", {31'b0, irq_out}, 32'h0);

        // R1 reset again from non-zero state
        wr(8'h08, 32'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_check("R1 pend after reset", 8'h00, 32'h0);
        rd_check("R1 mask after reset", 8'h0C, 32'h0);
        check("R1 irq after reset", {31'b0, irq_out}, 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule